// File: doc/BRIEF.md
# Masked content-addressable memory

This block holds a small array of data words and finds them by content instead of by address. A host loads a search pattern into the argument register and a per-bit enable into the mask register. When it pulses the search strobe, every stored word is compared with the pattern at the same time. Only the bit positions enabled by the mask take part. The outcome is a registered match vector with one bit per word.

After a search the matching words are presented one at a time, lowest index first. Each pulse of the advance input retires the word on display and brings up the next one. A done flag shows that the current search has no unread matches left.

Words are loaded by index through a write port. A word that has never been written is invalid and never matches.

Top module: `masked_cam`

## Requirements
- R1: After reset, `match_vec` is all zeros, `rd_valid` is 0, `rd_data` is 0 and `done` is 0.
- R2: A write with `wr_en`=1 stores `wr_data` at `wr_idx` and marks that word valid. Searches strobed in later cycles see the new contents.
- R3: One cycle after `search`=1, bit i of `match_vec` is 1 exactly when word i is valid and equals the argument on every enabled bit position. All words are compared in that same search.
- R4: Mask bit positions that hold 0 are ignored in the comparison. A word differing from the argument only on such positions still matches.
- R5: An all-zero mask makes every valid word match.
- R6: A word that was never written never sets its match bit, whatever the argument and mask hold.
- R7: `rd_idx` shows the lowest-index match not yet read out, and `rd_data` shows that word's contents. `rd_valid` is 1 while such a match exists and 0 otherwise, and `rd_data` is 0 when `rd_valid` is 0. A pulse on `rd_next` retires the displayed index, so the next index appears one cycle later in ascending order.
- R8: `done` is 1 once at least one search has been made and no unread match remains. It is 0 before the first search and while matches are pending.
- R9: `rd_next` has no effect when no unread match remains.
- R10: A search restarts the readout with its own match vector. When `search` and `rd_next` are both 1 in the same cycle, the search wins.
- R11: `arg_load` and `key_load` update the argument and mask registers one cycle later. A search strobed in the same cycle as a load uses the values held before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDXW | Word index to write |
| wr_data | input | WIDTH | Word contents to write |
| arg_load | input | 1 | Load the argument register |
| arg_in | input | WIDTH | New argument value |
| key_load | input | 1 | Load the mask register |
| key_in | input | WIDTH | New mask value, 1 = bit compared |
| search | input | 1 | Start a search |
| rd_next | input | 1 | Retire the displayed match |
| match_vec | output | WORDS | Registered match vector of the last search |
| rd_valid | output | 1 | An unread match is displayed |
| rd_idx | output | IDXW | Index of the displayed match |
| rd_data | output | WIDTH | Contents of the displayed word |
| done | output | 1 | Last search has no unread matches left |

## Verification
The cases hardest to reach from the ports are the collisions between strobes in one cycle. One is a search arriving together with an advance pulse. Another is a search arriving together with a load of the argument or mask. A third is a write to a word that is being displayed or compared. Directed steps force each of these collisions against a known array. A long run of random strobes then draws from a small pool of data and pattern values, so that many words match at once and the collisions occur over and over. A behavioural model is compared on every cycle.

// File: rtl/masked_cam.sv
module masked_cam #(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             arg_load,
  input  logic [WIDTH-1:0] arg_in,
  input  logic             key_load,
  input  logic [WIDTH-1:0] key_in,
  input  logic             search,
  input  logic             rd_next,
  output logic [WORDS-1:0] match_vec,
  output logic             rd_valid,
  output logic [IDXW-1:0]  rd_idx,
  output logic [WIDTH-1:0] rd_data,
  output logic             done
);

  logic [WIDTH-1:0] mem [WORDS];
  logic [WORDS-1:0] valid_q;
  logic [WIDTH-1:0] arg_q, key_q;
  logic [WORDS-1:0] match_q, pend_q, cmp;
  logic             searched_q;
  logic [WORDS-1:0] low_bit;

  always_comb begin
    for (int i = 0; i < WORDS; i++)
      cmp[i] = valid_q[i] && (((mem[i] ^ arg_q) & key_q) == '0);
  end

  always_comb begin
    rd_idx = '0;
    for (int i = WORDS - 1; i >= 0; i--)
      if (pend_q[i]) rd_idx = IDXW'(i);
  end

  assign low_bit   = pend_q & (~pend_q + 1'b1);
  assign rd_valid  = |pend_q;
  assign rd_data   = rd_valid ? mem[rd_idx] : '0;
  assign done      = searched_q & ~rd_valid;
  assign match_vec = match_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= '0;
      arg_q      <= '0;
      key_q      <= '0;
      match_q    <= '0;
      pend_q     <= '0;
      searched_q <= 1'b0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      if (search) begin
        match_q    <= cmp;
        pend_q     <= cmp;
        searched_q <= 1'b1;
      end else if (rd_next) begin
        pend_q <= pend_q & ~low_bit;
      end
      if (wr_en) begin
        mem[wr_idx]     <= wr_data;
        valid_q[wr_idx] <= 1'b1;
      end
      if (arg_load) arg_q <= arg_in;
      if (key_load) key_q <= key_in;
    end
  end

  assert_match_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_q & ~valid_q) == '0);

  assert_pend_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~match_q) == '0);

  assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_next && rd_valid && !search) |=> $countones(pend_q) == $countones($past(pend_q)) - 1);

  assert_idle_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!search && !rd_valid) |=> !rd_valid);

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    search |=> (pend_q == match_q) && !$past(done) || (pend_q == match_q));

  assert_done_after_search_R8: assert property (@(posedge clk) disable iff (!rst_n)
    search |=> searched_q);

endmodule

// File: tb/masked_cam_tb.sv
module masked_cam_tb;
  localparam int WORDS = 8;
  localparam int WIDTH = 16;
  localparam int IDXW  = 3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, arg_load = 0, key_load = 0, search = 0, rd_next = 0;
  logic [IDXW-1:0]  wr_idx = 0;
  logic [WIDTH-1:0] wr_data = 0, arg_in = 0, key_in = 0;
  logic [WORDS-1:0] match_vec;
  logic rd_valid, done;
  logic [IDXW-1:0]  rd_idx;
  logic [WIDTH-1:0] rd_data;

  masked_cam #(.WORDS(WORDS), .WIDTH(WIDTH)) u_dut (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_data, .arg_load, .arg_in,
    .key_load, .key_in, .search, .rd_next, .match_vec, .rd_valid,
    .rd_idx, .rd_data, .done);

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  logic [WIDTH-1:0] m_mem [WORDS];
  bit   m_val [WORDS];
  logic [WIDTH-1:0] m_arg = 0, m_key = 0;
  bit   m_match [WORDS];
  bit   m_pend  [WORDS];
  bit   m_searched = 0;

  function automatic int low_pend();
    for (int i = 0; i < WORDS; i++) if (m_pend[i]) return i;
    return -1;
  endfunction

  task automatic cmp1(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk(string tag);
    logic [WORDS-1:0] mv;
    int lp;
    for (int i = 0; i < WORDS; i++) mv[i] = m_match[i];
    lp = low_pend();
    cmp1(tag, "match_vec", match_vec, mv);
    cmp1(tag, "rd_valid", rd_valid, lp >= 0);
    cmp1(tag, "done", done, m_searched && lp < 0);
    if (lp >= 0) begin
      cmp1(tag, "rd_idx", rd_idx, lp);
      cmp1(tag, "rd_data", rd_data, m_mem[lp]);
    end else cmp1(tag, "rd_data", rd_data, 0);
  endtask

  task automatic step(string tag, bit we, int wi, logic [WIDTH-1:0] wd,
                      bit al, logic [WIDTH-1:0] ad, bit kl, logic [WIDTH-1:0] kd,
                      bit s, bit rn);
    bit c [WORDS];
    int lp;
    wr_en = we; wr_idx = IDXW'(wi); wr_data = wd;
    arg_load = al; arg_in = ad; key_load = kl; key_in = kd;
    search = s; rd_next = rn;
    @(posedge clk);
    for (int i = 0; i < WORDS; i++)
      c[i] = m_val[i] && (((m_mem[i] ^ m_arg) & m_key) == 0);
    lp = low_pend();
    if (s) begin
      for (int i = 0; i < WORDS; i++) begin m_match[i] = c[i]; m_pend[i] = c[i]; end
      m_searched = 1;
    end else if (rn && lp >= 0) m_pend[lp] = 0;
    if (we) begin m_mem[wi] = wd; m_val[wi] = 1; end
    if (al) m_arg = ad;
    if (kl) m_key = kd;
    @(negedge clk);
    chk(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [WIDTH-1:0] pool [4];
    pool = '{16'h12A5, 16'h12A4, 16'hFFA5, 16'h0000};
    for (int i = 0; i < WORDS; i++) begin m_mem[i] = 0; m_val[i] = 0; m_match[i] = 0; m_pend[i] = 0; end
    repeat (2) @(negedge clk);
    rst_n = 1;
    chk("R1");
    // R2: fill words 0..5, leave 6 and 7 unwritten
    step("R2", 1, 0, 16'h12A5, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 1, 16'h12A4, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 2, 16'h12A5, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 3, 16'hFFA5, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 4, 16'h0000, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 5, 16'h12A5, 0, 0, 0, 0, 0, 0);
    // R3: full mask exact match
    step("R3", 0, 0, 0, 1, 16'h12A5, 1, 16'hFFFF, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle("R3");
    // R4: low byte only
    step("R4", 0, 0, 0, 0, 0, 1, 16'h00FF, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R7/R8/R9: walk the matches
    for (int k = 0; k < 6; k++) step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R8");
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R5/R6: zero mask, unwritten words 6 and 7 must not match
    step("R5", 0, 0, 0, 1, 16'h0000, 1, 16'h0000, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R10: search together with rd_next
    step("R10", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    // R11: load and search together uses old key (zero) then new key
    step("R11", 0, 0, 0, 1, 16'h12A4, 1, 16'hFFFF, 1, 0);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R2: write word 7 then search with zero mask
    step("R2", 1, 7, 16'hBEEF, 0, 0, 1, 16'h0000, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R2", 1, 0, 16'h5555, 0, 0, 0, 0, 0, 0);
    // random phase over a small value pool
    for (int n = 0; n < 3000; n++) begin
      step("R3/R7/R10", ($urandom % 4) == 0, $urandom % WORDS, pool[$urandom % 4],
           ($urandom % 6) == 0, pool[$urandom % 4],
           ($urandom % 6) == 0, (($urandom % 2) != 0) ? 16'hFFFF : 16'h00FF,
           ($urandom % 5) == 0, ($urandom % 2) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule